// File: doc/BRIEF.md
# Tile-Mapped VGA Display Engine

This block produces a 640x480 picture at about 60 Hz from a 25 MHz pixel clock, without a frame buffer. An 8 KB on-chip video RAM is viewed as 64 rows of 128 bytes. The left 80 columns of the first 60 rows form a tile map with one index byte for each 8x8 screen tile. The right-hand columns of the first 48 rows hold up to 96 tile patterns. Each pattern row is three bytes, giving eight pixels of 3 bits each.

While one tile is on screen, a fetch pipeline reads the index byte of the next tile and then its three pattern bytes. At the tile boundary it loads them into a shift register. A processor fills the RAM through a byte-wide write port that is independent of the display side. The three colour bits go out with one bit for each of red, green and blue. The syncs and colour leave the same register stage, so they stay aligned.

Top module: `tile_vga_top`

## Requirements
- R1: `hsync_o` is low for exactly H_SYNC (96) consecutive cycles in every line and falls once every H_TOT (800) cycles. The first low cycle carries horizontal position H_VIS+H_FP (656).
- R2: `vsync_o` is low for exactly V_SYNC lines (V_SYNC*H_TOT cycles). It falls together with the output of position (0, V_VIS+V_FP) and repeats every V_TOT*H_TOT cycles.
- R3: `rgb_o` is 0 whenever the output position has x >= H_VIS or y >= V_VIS.
- R4: A visible pixel (x, y) shows tile index t, which is the byte at address (y/8)*128 + x/8. Its code is bits [23-3*(x%8) -: 3] of the 24-bit word {B0,B1,B2}, with B0 most significant. Pixel 0 is the leftmost pixel.
- R5: For tile t and pixel row r, pattern byte Bk (k = 0..2) is at address ((t/16)*8 + r)*128 + 80 + 3*(t%16) + k.
- R6: A tile index of 96 or more shows all eight pixels of every row as code 0.
- R7: When `wr_en_i` is high at a clock edge, `wr_data_i` is stored at `wr_addr_i`, and every later frame shows the new content. Writes in any cycle leave the sync timing of R1 and R2 unchanged.
- R8: While `rst_ni` is low, `hsync_o` = 1, `vsync_o` = 1 and `rgb_o` = 0.
- R9: Pixel x of a line appears H_BP + x (48 + x) cycles after the rising edge of `hsync_o` that ends the preceding sync pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the video RAM |
| wr_addr_i | input | 13 | Byte address of the write |
| wr_data_i | input | 8 | Byte to store |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active low |
| rgb_o | output | 3 | Pixel colour, one bit per channel |

## Verification
The checker assumes that reset is held for at least one clock and that the timing counters start from zero. Its window counters need one full pulse or period after reset before they judge a width or a spacing. The RAM has no reset, so the picture is defined only after it has been written. The bench therefore clears the whole RAM and loads a known map and known patterns before it compares anything. The bench shortens the vertical timing through parameters to keep frames short, while the horizontal timing stays at its default. Inputs change on falling clock edges, and writes during a measured frame go only to map rows that the shortened frame never shows.

// File: rtl/tile_vga_pkg.sv
package tile_vga_pkg;
  localparam int ADDR_W   = 13;
  localparam int DATA_W   = 8;
  localparam int PAT_COL0 = 80;
  localparam int TILE_CNT = 96;
  localparam int TILE_PX  = 8;
  localparam int PIX_W    = 3;
  localparam int PAT_W    = PIX_W * TILE_PX;

  typedef logic [ADDR_W-1:0] vaddr_t;
  typedef logic [DATA_W-1:0] vbyte_t;
  typedef logic [PIX_W-1:0]  rgb_t;

  function automatic vaddr_t map_addr(logic [5:0] ty, logic [6:0] tx);
    return {ty, tx};
  endfunction

  // pattern row = group*8 + r, column = 80 + 3*slot + byte
  function automatic vaddr_t pat_addr(logic [6:0] t, logic [2:0] r, logic [1:0] b);
    logic [6:0] col;
    col = 7'(PAT_COL0 + 3 * int'(t[3:0]) + int'(b));
    return {t[6:4], r, col};
  endfunction
endpackage

// File: rtl/vga_timing.sv
module vga_timing #(
  parameter int H_TOT = 800,
  parameter int V_TOT = 525,
  parameter int HW    = $clog2(H_TOT),
  parameter int VW    = $clog2(V_TOT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [HW-1:0] hcnt_o,
  output logic [VW-1:0] vcnt_o,
  output logic [VW-1:0] fline_o
);
  import tile_vga_pkg::*;

  logic h_end, v_end;
  assign h_end = (hcnt_o == HW'(H_TOT - 1));
  assign v_end = (vcnt_o == VW'(V_TOT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_o <= '0;
      vcnt_o <= '0;
    end else begin
      hcnt_o <= h_end ? '0 : hcnt_o + 1'b1;
      if (h_end) vcnt_o <= v_end ? '0 : vcnt_o + 1'b1;
    end
  end

  // last tile slot of a line fetches for the next line
  always_comb begin
    if (hcnt_o >= HW'(H_TOT - TILE_PX)) fline_o = v_end ? '0 : vcnt_o + 1'b1;
    else                                fline_o = vcnt_o;
  end
endmodule

// File: rtl/tile_vram.sv
module tile_vram #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wa_i,
  input  logic [DATA_W-1:0] wd_i,
  input  logic [ADDR_W-1:0] ra_i,
  output logic [DATA_W-1:0] rd_o
);
  localparam int LW    = $clog2(LANES);
  localparam int WORDS = (2 ** ADDR_W) / LANES;

  logic [LANES-1:0][DATA_W-1:0] mem [WORDS];
  logic [LANES-1:0][DATA_W-1:0] word_q;
  logic [LW-1:0]                lane_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[wa_i[ADDR_W-1:LW]][wa_i[LW-1:0]] <= wd_i;
  end

  always_ff @(posedge clk_i) begin
    word_q <= mem[ra_i[ADDR_W-1:LW]];
    lane_q <= ra_i[LW-1:0];
  end

  assign rd_o = word_q[lane_q];
endmodule

// File: rtl/tile_fetch.sv
module tile_fetch #(
  parameter int H_TOT = 800,
  parameter int HW    = 10,
  parameter int VW    = 10
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [HW-1:0]             hcnt_i,
  input  logic [VW-1:0]             fline_i,
  input  tile_vga_pkg::vbyte_t      rd_data_i,
  output tile_vga_pkg::vaddr_t      rd_addr_o,
  output tile_vga_pkg::rgb_t        pix_o
);
  import tile_vga_pkg::*;

  logic [2:0]       phase;
  logic [6:0]       tx;
  logic [5:0]       ty;
  logic [2:0]       prow;
  logic [6:0]       tile_q;
  logic             blank_q;
  vbyte_t           b0_q, b1_q, b2_q;
  logic [PAT_W-1:0] shreg_q;

  assign phase = hcnt_i[2:0];
  assign tx    = (hcnt_i >= HW'(H_TOT - TILE_PX)) ? 7'd0 : 7'(hcnt_i >> 3) + 7'd1;
  assign ty    = 6'(fline_i >> 3);
  assign prow  = fline_i[2:0];

  // slot 0: index, slots 1..3: pattern bytes (read latency 1)
  always_comb begin
    case (phase)
      3'd1:    rd_addr_o = pat_addr(rd_data_i[6:0], prow, 2'd0);
      3'd2:    rd_addr_o = pat_addr(tile_q, prow, 2'd1);
      3'd3:    rd_addr_o = pat_addr(tile_q, prow, 2'd2);
      default: rd_addr_o = map_addr(ty, tx);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tile_q  <= '0;
      blank_q <= 1'b1;
      b0_q    <= '0;
      b1_q    <= '0;
      b2_q    <= '0;
      shreg_q <= '0;
    end else begin
      case (phase)
        3'd1: begin
          tile_q  <= rd_data_i[6:0];
          blank_q <= (rd_data_i >= 8'(TILE_CNT));
        end
        3'd2: b0_q <= rd_data_i;
        3'd3: b1_q <= rd_data_i;
        3'd4: b2_q <= rd_data_i;
        default: ;
      endcase
      if (phase == 3'd7) shreg_q <= blank_q ? '0 : {b0_q, b1_q, b2_q};
      else               shreg_q <= shreg_q << PIX_W;
    end
  end

  assign pix_o = shreg_q[PAT_W-1 -: PIX_W];
endmodule

// File: rtl/tile_vga_top.sv
module tile_vga_top #(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [12:0] wr_addr_i,
  input  logic [7:0]  wr_data_i,
  output logic        hsync_o,
  output logic        vsync_o,
  output logic [2:0]  rgb_o
);
  import tile_vga_pkg::*;

  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HW    = $clog2(H_TOT);
  localparam int VW    = $clog2(V_TOT);
  localparam int HS0   = H_VIS + H_FP;
  localparam int VS0   = V_VIS + V_FP;

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic [VW-1:0] fline;
  vaddr_t        rd_addr;
  vbyte_t        rd_data;
  rgb_t          pix;
  logic          vis, hs_on, vs_on;

  vga_timing #(.H_TOT(H_TOT), .V_TOT(V_TOT), .HW(HW), .VW(VW)) u_timing (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hcnt_o (hcnt),
    .vcnt_o (vcnt),
    .fline_o(fline)
  );

  tile_vram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(4)) u_vram (
    .clk_i(clk_i),
    .we_i (wr_en_i),
    .wa_i (wr_addr_i),
    .wd_i (wr_data_i),
    .ra_i (rd_addr),
    .rd_o (rd_data)
  );

  tile_fetch #(.H_TOT(H_TOT), .HW(HW), .VW(VW)) u_fetch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hcnt_i   (hcnt),
    .fline_i  (fline),
    .rd_data_i(rd_data),
    .rd_addr_o(rd_addr),
    .pix_o    (pix)
  );

  assign vis   = (hcnt < HW'(H_VIS)) && (vcnt < VW'(V_VIS));
  assign hs_on = (hcnt >= HW'(HS0)) && (hcnt < HW'(HS0 + H_SYNC));
  assign vs_on = (vcnt >= VW'(VS0)) && (vcnt < VW'(VS0 + V_SYNC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsync_o <= 1'b1;
      vsync_o <= 1'b1;
      rgb_o   <= '0;
    end else begin
      hsync_o <= ~hs_on;
      vsync_o <= ~vs_on;
      rgb_o   <= vis ? pix : '0;
    end
  end
endmodule

// File: rtl/tile_vga_chk.sv
module tile_vga_chk #(
  parameter int H_VIS  = 640,
  parameter int V_VIS  = 480,
  parameter int H_TOT  = 800,
  parameter int H_SYNC = 96,
  parameter int V_SYNC = 2,
  parameter int HW     = 10,
  parameter int VW     = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          hsync_o,
  input logic          vsync_o,
  input logic [2:0]    rgb_o,
  input logic [HW-1:0] hcnt,
  input logic [VW-1:0] vcnt
);
  logic        hs_q, vs_q, h_seen;
  logic [31:0] h_low, v_low, h_per;
  logic        h_fall, h_rise, v_rise;

  assign h_fall = hs_q & ~hsync_o;
  assign h_rise = ~hs_q & hsync_o;
  assign v_rise = ~vs_q & vsync_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q   <= 1'b1;
      vs_q   <= 1'b1;
      h_seen <= 1'b0;
      h_low  <= '0;
      v_low  <= '0;
      h_per  <= '0;
    end else begin
      hs_q   <= hsync_o;
      vs_q   <= vsync_o;
      h_seen <= h_seen | h_fall;
      h_low  <= hsync_o ? '0 : h_low + 1;
      v_low  <= vsync_o ? '0 : v_low + 1;
      h_per  <= h_fall ? 32'd1 : h_per + 1;
    end
  end

  a_r1_hsync_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_rise |-> h_low == 32'(H_SYNC));

  a_r2_vsync_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_rise |-> v_low == 32'(V_SYNC * H_TOT));

  a_r7_line_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_fall && h_seen) |-> h_per == 32'(H_TOT));

  a_r3_blank_outside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(($past(hcnt) < HW'(H_VIS)) && ($past(vcnt) < VW'(V_VIS))) |-> rgb_o == 3'd0);
endmodule

bind tile_vga_top tile_vga_chk #(
  .H_VIS(H_VIS), .V_VIS(V_VIS), .H_TOT(H_TOT), .H_SYNC(H_SYNC),
  .V_SYNC(V_SYNC), .HW(HW), .VW(VW)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .hsync_o(hsync_o),
  .vsync_o(vsync_o),
  .rgb_o  (rgb_o),
  .hcnt   (hcnt),
  .vcnt   (vcnt)
);

// File: tb/tb_tile_vga_top.sv
module tb_tile_vga_top;
  localparam int H_VIS = 640, H_FP = 16, H_SYNC = 96, H_BP = 48;
  localparam int V_VIS = 16, V_FP = 2, V_SYNC = 2, V_BP = 3;
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int LINE0_OFS = (V_TOT - V_VIS - V_FP) * H_TOT;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [12:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        hs, vs;
  logic [2:0]  rgb;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit meas_done = 0;
  logic [31:0] shadow [2048];
  int px00, px08, px_16_8, rise_gap;

  always #2.5 clk = ~clk;

  tile_vga_top #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .hsync_o(hs), .vsync_o(vs), .rgb_o(rgb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sh_rd(input int a);
    return int'(shadow[a >> 2][8 * (a % 4) +: 8]);
  endfunction

  task automatic wr(input int a, input int d);
    wr_en   = 1'b1;
    wr_addr = 13'(a);
    wr_data = 8'(d);
    shadow[a >> 2][8 * (a % 4) +: 8] = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int exp_pix(input int x, input int y);
    int t, row, c;
    logic [23:0] p;
    if (x >= H_VIS || y >= V_VIS) return 0;
    t = sh_rd((y / 8) * 128 + x / 8);
    if (t >= 96) return 0;
    row = (t / 16) * 8 + y % 8;
    c   = 80 + 3 * (t % 16);
    p   = {8'(sh_rd(row * 128 + c)), 8'(sh_rd(row * 128 + c + 1)), 8'(sh_rd(row * 128 + c + 2))};
    return int'((p >> (21 - 3 * (x % 8))) & 24'd7);
  endfunction

  task automatic wait_vfall();
    logic p;
    p = vs;
    @(negedge clk);
    while (!(p && !vs)) begin
      p = vs;
      @(negedge clk);
    end
  endtask

  task automatic wait_hfall();
    logic p;
    p = hs;
    @(negedge clk);
    while (!(p && !hs)) begin
      p = hs;
      @(negedge clk);
    end
  endtask

  // capture one frame after a vsync fall and compare it with the shadow model
  task automatic capture_frame(input string tag);
    int bad_v = 0, bad_b = 0, bad_h = 0;
    int fv_a = 0, fv_e = 0, fb_a = 0, fb_e = 0, fh_a = 0, fh_e = 0;
    int since_rise = 0;
    logic hp;
    wait_vfall();
    hp = hs;
    for (int off = 1; off < LINE0_OFS + V_VIS * H_TOT; off++) begin
      @(negedge clk);
      if (!hp && hs) since_rise = 0;
      else since_rise++;
      hp = hs;
      if (off >= LINE0_OFS) begin
        int x, y, e, a, t;
        y = (off - LINE0_OFS) / H_TOT;
        x = (off - LINE0_OFS) % H_TOT;
        a = int'(rgb);
        e = exp_pix(x, y);
        if (x == 0 && y == 0) begin
          rise_gap = since_rise;
          px00 = a;
        end
        if (x == 8 && y == 0) px08 = a;
        if (x == 16 && y == 8) px_16_8 = a;
        if (x >= H_VIS) begin
          if (a != 0) begin
            if (bad_h == 0) begin fh_a = a; fh_e = 0; end
            bad_h++;
          end
        end else begin
          t = sh_rd((y / 8) * 128 + x / 8);
          if (a != e) begin
            if (t >= 96) begin
              if (bad_b == 0) begin fb_a = a; fb_e = e; end
              bad_b++;
            end else begin
              if (bad_v == 0) begin fv_a = a; fv_e = e; end
              bad_v++;
            end
          end
        end
      end
    end
    chk(bad_v == 0, {tag, " R4 R5 tile pixel"}, fv_a, fv_e);
    chk(bad_b == 0, {tag, " R6 high index black"}, fb_a, fb_e);
    chk(bad_h == 0, {tag, " R3 horizontal blank"}, fh_a, fh_e);
    chk(rise_gap == H_BP, {tag, " R9 first pixel after hsync rise"}, rise_gap, H_BP);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(hs == 1'b1, "R8 hsync in reset", int'(hs), 1);
    chk(vs == 1'b1, "R8 vsync in reset", int'(vs), 1);
    chk(rgb == 3'd0, "R8 rgb in reset", int'(rgb), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_load();
    for (int a = 0; a < 8192; a++) wr(a, 0);
    for (int t = 0; t < 96; t++)
      for (int r = 0; r < 8; r++)
        for (int k = 0; k < 3; k++)
          wr(((t / 16) * 8 + r) * 128 + 80 + 3 * (t % 16) + k, (t * 37 + r * 11 + k * 5 + 1) & 255);
    for (int r = 0; r < 8; r++) begin
      wr((0 * 8 + r) * 128 + 83, 8'hE0);
      wr((0 * 8 + r) * 128 + 84, 8'h00);
      wr((0 * 8 + r) * 128 + 85, 8'h00);
    end
    for (int ty = 0; ty < V_VIS / 8; ty++)
      for (int tx = 0; tx < 80; tx++)
        wr(ty * 128 + tx, (tx == 0) ? 1 : (tx * 7 + ty * 13) % 104);
  endtask

  task automatic t_hsync();
    int n = 0, m = 0;
    wait_hfall();
    while (!hs) begin n++; @(negedge clk); end
    while (hs) begin m++; @(negedge clk); end
    chk(n == H_SYNC, "R1 hsync low width", n, H_SYNC);
    chk(n + m == H_TOT, "R1 hsync period", n + m, H_TOT);
  endtask

  task automatic t_frame_base();
    capture_frame("base");
    chk(px00 == 7, "R4 tile 1 leftmost pixel", px00, 7);
  endtask

  task automatic t_write_timing();
    int low = 0, rest = 0, lit = 0;
    meas_done = 0;
    fork
      begin
        int i = 0;
        while (!meas_done) begin
          wr(40 * 128 + (i % 80), i & 255);
          i++;
        end
      end
      begin
        wait_vfall();
        while (!vs) begin
          low++;
          if (rgb != 3'd0) lit++;
          @(negedge clk);
        end
        while (vs) begin rest++; @(negedge clk); end
        meas_done = 1;
      end
    join
    chk(low == V_SYNC * H_TOT, "R2 vsync low width under writes R7", low, V_SYNC * H_TOT);
    chk(low + rest == V_TOT * H_TOT, "R2 frame period under writes R7", low + rest, V_TOT * H_TOT);
    chk(lit == 0, "R3 rgb during vertical sync", lit, 0);
  endtask

  task automatic t_update();
    for (int r = 0; r < 8; r++) begin
      wr((5 * 8 + r) * 128 + 80 + 45, 8'h92);
      wr((5 * 8 + r) * 128 + 80 + 46, 8'h49);
      wr((5 * 8 + r) * 128 + 80 + 47, 8'h24);
    end
    wr(0, 95);
    wr(1, 200);
    wr(128 + 2, 96);
    capture_frame("update R7");
    chk(px00 == 4, "R7 rewritten tile shows tile 95", px00, 4);
    chk(px08 == 0, "R6 index 200 black", px08, 0);
    chk(px_16_8 == 0, "R6 index 96 black", px_16_8, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", 190000, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_load();
    t_hsync();
    t_frame_base();
    t_write_timing();
    t_update();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule